// File: doc/BRIEF.md
# Descriptor Ring DMA Walker

This block is a single-channel engine that follows a chain of buffer descriptors kept in a word-wide memory. Software writes the descriptors, hands them to the engine by setting an ownership flag, and pulses a start strobe with the address of the first descriptor. The engine then repeats one cycle of work per descriptor. It reads the descriptor and checks that it owns it. It copies the described buffer, unit by unit, into a peripheral FIFO port, applying the requested unit width and optional byte reversal. It writes the status back with ownership returned to software. Finally it either steps to the next descriptor, returns to the first one, or stops.

Each descriptor is two words, or three when its extended flag is set. The first word packs a 16-bit unit count in bits [15:0], a status byte in bits [23:16] and a command byte in bits [31:24]. The second word is the byte address of the buffer. The optional third word is skipped. The buffer holds one unit per 32-bit word, so the buffer address advances by 4 per unit. Memory reads have a fixed latency of one cycle. A fault flag that arrives with read data marks a failed buffer read. Address and pointer widths are parameters of at most 32 bits.

Top module: `desc_ring_walker`

## Requirements
- R1: A start pulse while idle loads the base pointer. On the next cycle busy is high and a read of the first descriptor word is issued at the base address.
- R2: If the first descriptor word has status bit 16 (ownership) clear, the engine writes nothing, moves no data, and drops busy on the cycle after that word returns.
- R3: For an owned descriptor with count N, exactly N FIFO writes occur. Unit k is taken from buffer address + 4*k, in ascending order.
- R4: Command bits [25:24] select the unit width: 0 keeps all 32 bits, 1 keeps the low 8 bits, 2 keeps the low 16 bits, and 3 keeps the low 24 bits. Dropped upper bytes read as zero.
- R5: Command bit 31 reverses the byte order inside the unit. With U bytes kept, output byte i is input byte U-1-i.
- R6: After the last unit, the first descriptor word is written back at the descriptor address. Bit 16 is cleared and every other bit is unchanged, except bit 20 on a fault.
- R7: Status bit 19 produces a one-cycle interrupt pulse on the cycle after that descriptor's write-back.
- R8: Status bit 18 continues the walk. The next descriptor is at the current address + 8, or + 12 when status bit 23 (extended) is set.
- R9: Status bit 17 continues the walk at the base pointer instead of the next address, forming a ring that runs until an unowned descriptor is met.
- R10: A fault during a buffer read stops the data move. The write-back then has bit 20 set and bit 16 clear, chan_err rises, and the walk ends whatever the continue and ring bits say.
- R11: A descriptor with count 0 moves no data but is still written back.
- R12: A start pulse while busy is ignored. chan_err stays high until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe for a walk |
| base_ptr | input | AW | Byte address of the first descriptor |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| mem_fault | input | 1 | Fault flag, valid with mem_rdata |
| fifo_wr | output | 1 | Peripheral FIFO write strobe |
| fifo_wdata | output | 32 | Formatted unit for the FIFO |
| irq | output | 1 | One-cycle completion interrupt |
| busy | output | 1 | Walk in progress |
| chan_err | output | 1 | Sticky channel error |

## Verification
The first descriptor read appears one cycle after start is sampled. The ownership decision takes effect two cycles after that. Each unit costs two cycles, and its FIFO write comes one cycle after its buffer read. The write-back follows the last unit. The interrupt comes one cycle after the write-back, and busy falls one cycle later again. The bench drives inputs and samples outputs on the falling edge. It checks start acceptance exactly one cycle after the pulse. For whole walks it waits for busy to fall and then inspects the logged FIFO words, the memory image and the interrupt log. The bench independently confirms that every interrupt pulse directly follows a write.

// File: rtl/drw_pkg.sv
package drw_pkg;

    localparam int WORD_W      = 32;
    localparam int STAT_LSB    = 16;
    localparam int CMD_LSB     = 24;

    // bit positions inside the status byte
    localparam int ST_OWN  = 0;
    localparam int ST_RING = 1;
    localparam int ST_MORE = 2;
    localparam int ST_IRQ  = 3;
    localparam int ST_ERR  = 4;
    localparam int ST_EXT  = 7;

    // bit position inside the command byte
    localparam int CMD_SWAP = 7;

    localparam int UNIT_BYTES = WORD_W / 8;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [7:0]  stat;
        logic [15:0] count;
    } desc_head_t;

    typedef enum logic [3:0] {
        W_IDLE,
        W_HEAD_RD,
        W_HEAD_CAP,
        W_BUF_CAP,
        W_UNIT_RD,
        W_UNIT_CAP,
        W_WRITEBACK,
        W_STEP
    } walk_state_e;

    typedef enum logic [1:0] {
        UW_32 = 2'd0,
        UW_8  = 2'd1,
        UW_16 = 2'd2,
        UW_24 = 2'd3
    } unit_width_e;

    function automatic logic [2:0] unit_bytes(input unit_width_e w);
        return (w == UW_32) ? 3'd4 : {1'b0, w};
    endfunction

endpackage

// File: rtl/drw_unit_fmt.sv
module drw_unit_fmt
    import drw_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    input  logic [1:0]        width_code,
    input  logic              swap,
    output logic [WORD_W-1:0] unit
);
    logic [2:0] nbytes;

    assign nbytes = unit_bytes(unit_width_e'(width_code));

    for (genvar i = 0; i < UNIT_BYTES; i++) begin : g_lane
        logic [1:0] src;
        always_comb begin
            src = swap ? 2'(nbytes - 3'd1 - 3'(i)) : 2'(i);
            if (3'(i) < nbytes)
                unit[8*i +: 8] = raw[{src, 3'b000} +: 8];
            else
                unit[8*i +: 8] = 8'h00;
        end
    end

endmodule

// File: rtl/drw_next_ptr.sv
module drw_next_ptr #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_ptr,
    input  logic [AW-1:0] ring_base,
    input  logic          to_base,
    input  logic          extended,
    output logic [AW-1:0] next_ptr
);
    localparam logic [AW-1:0] SHORT_STEP = AW'(8);
    localparam logic [AW-1:0] LONG_STEP  = AW'(12);

    always_comb begin
        if (to_base)
            next_ptr = ring_base;
        else
            next_ptr = cur_ptr + (extended ? LONG_STEP : SHORT_STEP);
    end

endmodule

// File: rtl/drw_ctrl.sv
module drw_ctrl
    import drw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     base_ptr,
    input  logic [AW-1:0]     next_ptr,
    output logic [AW-1:0]     cur_ptr,
    output logic [AW-1:0]     ring_base,
    output logic              to_base,
    output logic              extended,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_fault,
    output logic              fifo_wr,
    output logic [1:0]        width_code,
    output logic              swap,
    output logic              irq,
    output logic              busy,
    output logic              chan_err
);
    localparam logic [AW-1:0] WORD_STEP = AW'(4);

    walk_state_e state;
    desc_head_t  head;
    logic [AW-1:0] buf_ptr;
    logic [15:0]   remain;
    logic          fault_seen;
    logic [7:0]    stat_wb;
    logic          head_owned;

    assign head_owned = mem_rdata[STAT_LSB + ST_OWN];

    assign to_base    = head.stat[ST_RING];
    assign extended   = head.stat[ST_EXT];
    assign width_code = head.cmd[1:0];
    assign swap       = head.cmd[CMD_SWAP];
    assign busy       = (state != W_IDLE);

    always_comb begin
        stat_wb          = head.stat;
        stat_wb[ST_OWN]  = 1'b0;
        if (fault_seen)
            stat_wb[ST_ERR] = 1'b1;
    end

    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = cur_ptr;
        mem_wdata = {head.cmd, stat_wb, head.count};
        unique case (state)
            W_HEAD_RD:   mem_rd = 1'b1;
            W_HEAD_CAP: begin
                mem_rd   = head_owned;
                mem_addr = cur_ptr + WORD_STEP;
            end
            W_UNIT_RD: begin
                mem_rd   = 1'b1;
                mem_addr = buf_ptr;
            end
            W_WRITEBACK: mem_wr = 1'b1;
            default: ;
        endcase
    end

    assign fifo_wr = (state == W_UNIT_CAP) && !mem_fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= W_IDLE;
            head       <= '0;
            cur_ptr    <= '0;
            ring_base  <= '0;
            buf_ptr    <= '0;
            remain     <= '0;
            fault_seen <= 1'b0;
            irq        <= 1'b0;
            chan_err   <= 1'b0;
        end else begin
            irq <= (state == W_WRITEBACK) && head.stat[ST_IRQ];
            unique case (state)
                W_IDLE: begin
                    if (start) begin
                        cur_ptr   <= base_ptr;
                        ring_base <= base_ptr;
                        chan_err  <= 1'b0;
                        state     <= W_HEAD_RD;
                    end
                end
                W_HEAD_RD:  state <= W_HEAD_CAP;
                W_HEAD_CAP: begin
                    head  <= desc_head_t'(mem_rdata);
                    state <= head_owned ? W_BUF_CAP : W_IDLE;
                end
                W_BUF_CAP: begin
                    buf_ptr    <= mem_rdata[AW-1:0];
                    remain     <= head.count;
                    fault_seen <= 1'b0;
                    state      <= (head.count == 16'd0) ? W_WRITEBACK : W_UNIT_RD;
                end
                W_UNIT_RD:  state <= W_UNIT_CAP;
                W_UNIT_CAP: begin
                    if (mem_fault) begin
                        fault_seen <= 1'b1;
                        chan_err   <= 1'b1;
                        state      <= W_WRITEBACK;
                    end else begin
                        buf_ptr <= buf_ptr + WORD_STEP;
                        remain  <= remain - 16'd1;
                        state   <= (remain == 16'd1) ? W_WRITEBACK : W_UNIT_RD;
                    end
                end
                W_WRITEBACK: state <= W_STEP;
                W_STEP: begin
                    if (fault_seen || !(head.stat[ST_MORE] || head.stat[ST_RING])) begin
                        state <= W_IDLE;
                    end else begin
                        cur_ptr <= next_ptr;
                        state   <= W_HEAD_RD;
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    // R1
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && mem_rd && mem_addr == $past(base_ptr)));

    // R2
    unowned_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (state == W_HEAD_CAP && !head_owned) |=> !busy);

    // R3
    fifo_in_walk_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> busy);

    // R6
    wb_owner_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> !mem_wdata[STAT_LSB + ST_OWN]);

    // R7
    irq_after_wb_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(mem_wr));

    // R10
    fault_halts_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_wdata[STAT_LSB + ST_ERR] && !$past(mem_rdata[STAT_LSB + ST_ERR]))
        |=> ##1 !busy);

    // R6
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

endmodule

// File: rtl/desc_ring_walker.sv
module desc_ring_walker
    import drw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     base_ptr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_fault,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_wdata,
    output logic              irq,
    output logic              busy,
    output logic              chan_err
);
    logic [AW-1:0] cur_ptr;
    logic [AW-1:0] ring_base;
    logic [AW-1:0] next_ptr;
    logic          to_base;
    logic          extended;
    logic [1:0]    width_code;
    logic          swap;

    drw_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .base_ptr   (base_ptr),
        .next_ptr   (next_ptr),
        .cur_ptr    (cur_ptr),
        .ring_base  (ring_base),
        .to_base    (to_base),
        .extended   (extended),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_fault  (mem_fault),
        .fifo_wr    (fifo_wr),
        .width_code (width_code),
        .swap       (swap),
        .irq        (irq),
        .busy       (busy),
        .chan_err   (chan_err)
    );

    drw_next_ptr #(.AW(AW)) u_next (
        .cur_ptr   (cur_ptr),
        .ring_base (ring_base),
        .to_base   (to_base),
        .extended  (extended),
        .next_ptr  (next_ptr)
    );

    drw_unit_fmt u_fmt (
        .raw        (mem_rdata),
        .width_code (width_code),
        .swap       (swap),
        .unit       (fifo_wdata)
    );

endmodule

// File: tb/test_desc_ring_walker.sv
`timescale 1ns/1ps
module test_desc_ring_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] base_ptr = '0;
    logic        mem_rd, mem_wr, fifo_wr, irq, busy, chan_err;
    logic [31:0] mem_addr, mem_wdata, fifo_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_fault = 1'b0;

    always #2.5 clk = ~clk;

    desc_ring_walker #(.AW(32)) i_desc_ring_walker (
        .clk(clk), .rst(rst), .start(start), .base_ptr(base_ptr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_fault(mem_fault),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .irq(irq), .busy(busy), .chan_err(chan_err)
    );

    // memory model: 64 words, one-cycle read latency
    logic [31:0] mem [64];
    logic [31:0] fault_addr = 32'hFFFF_FFF0;

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:2]];
        mem_fault <= mem_rd && (mem_addr == fault_addr);
        if (mem_wr) mem[mem_addr[7:2]] <= mem_wdata;
    end

    // logs
    logic [31:0] flog [256];
    int fcnt = 0, icnt = 0, irq_orphan = 0;
    logic wr_prev = 1'b0;
    always @(posedge clk) begin
        if (fifo_wr) begin
            flog[fcnt[7:0]] <= fifo_wdata;
            fcnt <= fcnt + 1;
        end
        if (irq) begin
            icnt <= icnt + 1;
            if (!wr_prev) irq_orphan <= irq_orphan + 1;
        end
        wr_prev <= mem_wr;
    end

    int total = 0, fails = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected unit formatting, from R4 and R5
    function automatic logic [31:0] exp_unit(input logic [31:0] raw, input logic [7:0] cmd);
        int n;
        logic [31:0] r;
        n = (cmd[1:0] == 2'd0) ? 4 : int'(cmd[1:0]);
        r = '0;
        for (int i = 0; i < n; i++)
            r[8*i +: 8] = cmd[7] ? raw[8*(n-1-i) +: 8] : raw[8*i +: 8];
        return r;
    endfunction

    task automatic clr_mem();
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    endtask

    task automatic run(input logic [31:0] base);
        int t;
        @(negedge clk);
        start = 1'b1;
        base_ptr = base;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (busy && t < 3000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [7:0]  cmd;
        logic [7:0]  stat;
        logic [15:0] cnt;
        logic [31:0] seed;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h00, 8'h01, 16'd2, 32'hA1B2C3D4},  // R3 R4 32-bit
        '{8'h01, 8'h01, 16'd3, 32'h11223344},  // R4 8-bit
        '{8'h02, 8'h09, 16'd1, 32'hCAFEBABE},  // R4 16-bit, R7
        '{8'h83, 8'h01, 16'd2, 32'h12345678},  // R5 24-bit swap
        '{8'h80, 8'h09, 16'd1, 32'hDEADBEEF},  // R5 32-bit swap, R7
        '{8'h00, 8'h01, 16'd0, 32'h0BADF00D},  // R11 empty
        '{8'h00, 8'h08, 16'd2, 32'h55AA55AA},  // R2 not owned
        '{8'h82, 8'h01, 16'd1, 32'h0000A5C3}   // R5 16-bit swap
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        int f0, i0;
        clr_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk("R1 reset busy", {31'b0, busy}, 32'd0);
        chk("R7 reset irq", {31'b0, irq}, 32'd0);
        chk("R10 reset chan_err", {31'b0, chan_err}, 32'd0);
        chk("R6 reset mem_wr", {31'b0, mem_wr}, 32'd0);
        chk("R3 reset fifo_wr", {31'b0, fifo_wr}, 32'd0);

        // vector table: one descriptor at 0x00, buffer at 0x80
        foreach (VECS[v]) begin
            vec_t tv;
            logic owned;
            tv = VECS[v];
            owned = tv.stat[0];
            clr_mem();
            mem[0] = {tv.cmd, tv.stat, tv.cnt};
            mem[1] = 32'h80;
            for (int k = 0; k < 4; k++) mem[32 + k] = tv.seed ^ (32'h1111_1111 * k);
            f0 = fcnt;
            i0 = icnt;
            run(32'h0);
            chk($sformatf("R3 vec%0d unit count", v), 32'(fcnt - f0),
                owned ? 32'(tv.cnt) : 32'd0);
            for (int k = 0; k < int'(tv.cnt) && owned; k++)
                chk($sformatf("R4 R5 vec%0d unit%0d", v, k), flog[f0 + k],
                    exp_unit(tv.seed ^ (32'h1111_1111 * k), tv.cmd));
            chk($sformatf("R6 R2 R11 vec%0d writeback", v), mem[0],
                owned ? {tv.cmd, tv.stat & 8'hFE, tv.cnt} : {tv.cmd, tv.stat, tv.cnt});
            chk($sformatf("R7 vec%0d irq count", v), 32'(icnt - i0),
                (owned && tv.stat[3]) ? 32'd1 : 32'd0);
            chk($sformatf("R2 vec%0d busy low", v), {31'b0, busy}, 32'd0);
        end

        // R1: start accepted, first read one cycle later at the base
        clr_mem();
        mem[4] = 32'h0005_0001;   // 0x10: own|more, count 1
        mem[5] = 32'h80;
        mem[6] = 32'h000B_0001;   // 0x18: own|ring|irq, count 1
        mem[7] = 32'h84;
        mem[8] = 32'h0001_0001;   // 0x20 decoy: owned, count 1
        mem[9] = 32'h88;
        mem[32] = 32'h111; mem[33] = 32'h222; mem[34] = 32'h333;
        f0 = fcnt;
        i0 = icnt;
        @(negedge clk);
        start = 1'b1;
        base_ptr = 32'h10;
        @(negedge clk);
        start = 1'b0;
        chk("R1 busy after start", {31'b0, busy}, 32'd1);
        chk("R1 first read", {31'b0, mem_rd}, 32'd1);
        chk("R1 first address", mem_addr, 32'h10);
        begin
            int t = 0;
            while (busy && t < 3000) begin @(negedge clk); t++; end
        end
        @(negedge clk);
        // R9 ring: back to 0x10, now unowned, stops; decoy untouched
        chk("R9 ring unit count", 32'(fcnt - f0), 32'd2);
        chk("R8 R9 second unit", flog[f0 + 1], 32'h222);
        chk("R9 first wb", mem[4], 32'h0004_0001);
        chk("R9 second wb", mem[6], 32'h000A_0001);
        chk("R9 decoy untouched", mem[8], 32'h0001_0001);
        chk("R7 ring irq", 32'(icnt - i0), 32'd1);

        // R8 extended step of 12
        clr_mem();
        mem[8]  = 32'h0085_0001;  // 0x20: own|more|ext
        mem[9]  = 32'h90;
        mem[10] = 32'h0001_0001;  // 0x28 extension word
        mem[11] = 32'h0001_0001;  // 0x2C: own, count 1
        mem[12] = 32'h94;
        mem[36] = 32'h1234_0F0F;
        mem[37] = 32'h5A5A_0F0F;
        f0 = fcnt;
        run(32'h20);
        chk("R8 ext unit count", 32'(fcnt - f0), 32'd2);
        chk("R8 ext second unit", flog[f0 + 1], 32'h5A5A_0F0F);
        chk("R8 ext second wb", mem[11], 32'h0000_0001);

        // R10 fault on the second buffer word
        clr_mem();
        mem[0] = 32'h000D_0003;   // own|more|irq, count 3
        mem[1] = 32'h80;
        mem[2] = 32'h0001_0001;   // next descriptor, owned
        mem[3] = 32'h90;
        mem[32] = 32'hAAAA_0001; mem[33] = 32'hAAAA_0002; mem[34] = 32'hAAAA_0003;
        fault_addr = 32'h84;
        f0 = fcnt;
        i0 = icnt;
        run(32'h0);
        fault_addr = 32'hFFFF_FFF0;
        chk("R10 units before fault", 32'(fcnt - f0), 32'd1);
        chk("R10 fault wb", mem[0], 32'h001C_0003);
        chk("R10 chan_err set", {31'b0, chan_err}, 32'd1);
        chk("R10 walk stopped", mem[2], 32'h0001_0001);
        chk("R7 fault irq", 32'(icnt - i0), 32'd1);

        // R12 chan_err cleared by next start; start while busy ignored
        clr_mem();
        mem[0]  = 32'h0001_0004;  // own, count 4
        mem[1]  = 32'h80;
        mem[16] = 32'h0001_0001;  // 0x40 other descriptor
        mem[17] = 32'h90;
        for (int k = 0; k < 4; k++) mem[32 + k] = 32'hB0 + k;
        f0 = fcnt;
        @(negedge clk);
        start = 1'b1;
        base_ptr = 32'h0;
        @(negedge clk);
        start = 1'b0;
        chk("R12 chan_err cleared", {31'b0, chan_err}, 32'd0);
        repeat (3) @(negedge clk);
        start = 1'b1;
        base_ptr = 32'h40;
        @(negedge clk);
        start = 1'b0;
        begin
            int t = 0;
            while (busy && t < 3000) begin @(negedge clk); t++; end
        end
        repeat (4) @(negedge clk);
        chk("R12 unit count", 32'(fcnt - f0), 32'd4);
        chk("R12 last unit", flog[f0 + 3], 32'hB3);
        chk("R12 other desc untouched", mem[16], 32'h0001_0001);
        chk("R7 no orphan irq", 32'(irq_orphan), 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule